// File: doc/BRIEF.md
# Flash memory command interface controller

This block sits between a host bus and a small behavioural NOR-style flash array. The host drives chip enable, write enable, output enable, an address and a 16-bit data bus, all active low for the strobes. A bus write is taken when the window in which both chip enable and write enable are low closes. Whichever strobe rises first ends the window, and the address and data seen in the last clock cycle of that window are used. The low byte of the captured data is decoded as a command.

Single-cycle commands select what a read returns: the array contents, a pair of identifier codes, or an 8-bit status byte. Another single-cycle command clears the error flags. Two-cycle sequences start a word program or a block erase. These jobs run in an internal write state machine whose busy phase is a parameterised cycle count, and a running job can be suspended and then resumed. The lowest block is the boot block. It may only be programmed or erased while the host holds the high-voltage protect flag.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array, `ready` is 1, the status byte reads 0x80 and every array word reads 0xFFFF.
- R2: In array mode a read (ce_n=0, oe_n=0) returns the stored word at `addr`. Whenever ce_n or oe_n is high, `dq_out` is 0x0000.
- R3: Command 0x90 selects identifier mode. A read at an even address returns 0x00B0 and a read at an odd address returns 0x00EC.
- R4: Command 0x70 selects status mode, and any address then reads {8'h00, status}. Status bit 7 is ready, bit 6 is erase suspended, bit 5 is erase error, bit 4 is program error, bit 3 is protect error, bit 2 is program suspended, and bits 1:0 are 0.
- R5: A write is accepted when the low-low window of ce_n and we_n closes, whichever strobe rises first. It uses the address and data present in the last clock cycle of that window.
- R6: Command 0x40 or 0x10, followed by a data write, programs that address with old AND data. `ready` is low for PROG_CYC cycles, and the read mode becomes status.
- R7: Command 0x20, followed by 0xD0 at any address, sets all 16 words of that address's block (block index addr[7:4]) to 0xFFFF after ERASE_CYC busy cycles.
- R8: An erase confirm other than 0xD0 sets status bits 5 and 4, erases nothing and returns to the idle command state.
- R9: A program or erase aimed at block 0 while `prot_hv`=0 sets status bits 5, 4 and 3 and leaves the array unchanged. With `prot_hv`=1 the same operation succeeds.
- R10: Command 0x50 clears status bits 5, 4 and 3.
- R11: Command 0xB0 during a busy job suspends it. `ready` goes to 1 and bit 6 (erase) or bit 2 (program) is set, while the array still holds its old data. Command 0xD0 while suspended resumes the job, which then completes.
- R12: A reserved command code, or a setup code (0x20/0x40/0x10) issued while a job is busy or suspended, changes neither the read mode nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| dq_in | input | DW | Write data / command byte in bits 7:0 |
| dq_out | output | DW | Read data |
| prot_hv | input | 1 | High-voltage level present on the protect pin |
| ready | output | 1 | 1 when no job is actively running |

## Verification
The bound checker watches several properties on every clock. It checks that the data bus is quiet when not read and that the status word always has its fixed zero bits. It checks that every launch is followed by a busy cycle and every suspend by a ready cycle. It also checks that no job is launched into the boot block without the high-voltage flag, and that a reserved code never moves the read mode. Other behaviours depend on data and on long sequences, and only the bench's scenarios can show them. These are the AND-only program result, erasure of exactly one block, the error bits after a bad confirm or a locked boot block, the clearing of those bits, and suspend and resume leaving the array unchanged until completion. The same holds for strobe-order capture and for setup codes being ignored while busy. The bench compares read data and `ready` against its behavioural model on every clock.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] OP_RD_ARRAY   = 8'hFF;
    localparam logic [7:0] OP_RD_IDENT   = 8'h90;
    localparam logic [7:0] OP_RD_STATUS  = 8'h70;
    localparam logic [7:0] OP_CLR_STATUS = 8'h50;
    localparam logic [7:0] OP_ERASE_SET  = 8'h20;
    localparam logic [7:0] OP_PROG_SET_A = 8'h40;
    localparam logic [7:0] OP_PROG_SET_B = 8'h10;
    localparam logic [7:0] OP_SUSPEND    = 8'hB0;
    localparam logic [7:0] OP_CONFIRM    = 8'hD0;

    typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_IDENT = 2'd1, RD_STATUS = 2'd2} rd_mode_e;
    typedef enum logic [1:0] {PEND_NONE = 2'd0, PEND_ERASE = 2'd1, PEND_PROG = 2'd2} pend_e;
    typedef enum logic [1:0] {WSM_IDLE = 2'd0, WSM_BUSY = 2'd1, WSM_SUSP = 2'd2} wsm_st_e;
    typedef enum logic {JOB_PROG = 1'b0, JOB_ERASE = 1'b1} job_e;

    typedef struct packed {
        rd_mode_e mode;
        pend_e    pend;
        logic     err_erase;
        logic     err_prog;
        logic     err_prot;
    } cmd_state_t;

    function automatic logic op_known(input logic [7:0] op);
        return op inside {OP_RD_ARRAY, OP_RD_IDENT, OP_RD_STATUS, OP_CLR_STATUS,
                          OP_ERASE_SET, OP_PROG_SET_A, OP_PROG_SET_B, OP_SUSPEND, OP_CONFIRM};
    endfunction

endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    typedef struct packed {
        logic          act;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } cap_t;

    cap_t cap_d, cap_q;
    logic act_now;

    always_comb begin
        act_now   = !ce_n && !we_n;
        cap_d     = cap_q;
        cap_d.act = act_now;
        if (act_now) begin
            cap_d.a = addr;
            cap_d.d = dq_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    // window closes when either strobe has risen
    assign wr_stb  = cap_q.act && !act_now;
    assign wr_addr = cap_q.a;
    assign wr_data = cap_q.d;

endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
#(
    parameter int BN_W     = 4,
    parameter int BOOT_BLK = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic [7:0]      cmd,
    input  logic [BN_W-1:0] wr_blk,
    input  logic            prot_hv,
    input  wsm_st_e         wsm_st,
    output rd_mode_e        rd_mode,
    output pend_e           pend,
    output logic            err_erase,
    output logic            err_prog,
    output logic            err_prot,
    output logic            go_prog,
    output logic            go_erase,
    output logic            do_susp,
    output logic            do_resume
);

    localparam logic [BN_W-1:0] BOOT_IDX = BN_W'(BOOT_BLK);

    cmd_state_t st_d, st_q;
    logic       locked;

    always_comb begin
        st_d      = st_q;
        go_prog   = 1'b0;
        go_erase  = 1'b0;
        do_susp   = 1'b0;
        do_resume = 1'b0;
        locked    = (wr_blk == BOOT_IDX) && !prot_hv;
        if (wr_stb) begin
            case (st_q.pend)
                PEND_PROG: begin
                    st_d.pend = PEND_NONE;
                    st_d.mode = RD_STATUS;
                    if (locked) begin
                        st_d.err_erase = 1'b1;
                        st_d.err_prog  = 1'b1;
                        st_d.err_prot  = 1'b1;
                    end else begin
                        go_prog = 1'b1;
                    end
                end
                PEND_ERASE: begin
                    st_d.pend = PEND_NONE;
                    st_d.mode = RD_STATUS;
                    if (cmd != OP_CONFIRM) begin
                        st_d.err_erase = 1'b1;
                        st_d.err_prog  = 1'b1;
                    end else if (locked) begin
                        st_d.err_erase = 1'b1;
                        st_d.err_prog  = 1'b1;
                        st_d.err_prot  = 1'b1;
                    end else begin
                        go_erase = 1'b1;
                    end
                end
                default: begin
                    case (cmd)
                        OP_RD_ARRAY:  st_d.mode = RD_ARRAY;
                        OP_RD_IDENT:  st_d.mode = RD_IDENT;
                        OP_RD_STATUS: st_d.mode = RD_STATUS;
                        OP_CLR_STATUS: begin
                            st_d.err_erase = 1'b0;
                            st_d.err_prog  = 1'b0;
                            st_d.err_prot  = 1'b0;
                        end
                        OP_ERASE_SET: begin
                            if (wsm_st == WSM_IDLE) begin
                                st_d.pend = PEND_ERASE;
                                st_d.mode = RD_STATUS;
                            end
                        end
                        OP_PROG_SET_A, OP_PROG_SET_B: begin
                            if (wsm_st == WSM_IDLE) begin
                                st_d.pend = PEND_PROG;
                                st_d.mode = RD_STATUS;
                            end
                        end
                        OP_SUSPEND: begin
                            st_d.mode = RD_STATUS;
                            do_susp   = (wsm_st == WSM_BUSY);
                        end
                        OP_CONFIRM: begin
                            st_d.mode = RD_STATUS;
                            do_resume = (wsm_st == WSM_SUSP);
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode      <= RD_ARRAY;
            st_q.pend      <= PEND_NONE;
            st_q.err_erase <= 1'b0;
            st_q.err_prog  <= 1'b0;
            st_q.err_prot  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_mode   = st_q.mode;
    assign pend      = st_q.pend;
    assign err_erase = st_q.err_erase;
    assign err_prog  = st_q.err_prog;
    assign err_prot  = st_q.err_prot;

endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
    import flash_cmd_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 16,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_prog,
    input  logic          go_erase,
    input  logic          do_susp,
    input  logic          do_resume,
    input  logic [AW-1:0] job_addr,
    input  logic [DW-1:0] job_data,
    output wsm_st_e       st,
    output job_e          kind,
    output logic          commit_prog,
    output logic          commit_erase,
    output logic [AW-1:0] tgt_addr,
    output logic [DW-1:0] tgt_data
);

    localparam int LONGEST = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(LONGEST) + 1;

    typedef struct packed {
        wsm_st_e          st;
        job_e             kind;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
    } wsm_t;

    wsm_t w_d, w_q;

    always_comb begin
        w_d          = w_q;
        commit_prog  = 1'b0;
        commit_erase = 1'b0;
        case (w_q.st)
            WSM_IDLE: begin
                if (go_prog) begin
                    w_d.st   = WSM_BUSY;
                    w_d.kind = JOB_PROG;
                    w_d.cnt  = CNT_W'(PROG_CYC - 1);
                    w_d.addr = job_addr;
                    w_d.data = job_data;
                end else if (go_erase) begin
                    w_d.st   = WSM_BUSY;
                    w_d.kind = JOB_ERASE;
                    w_d.cnt  = CNT_W'(ERASE_CYC - 1);
                    w_d.addr = job_addr;
                end
            end
            WSM_BUSY: begin
                if (do_susp) begin
                    w_d.st = WSM_SUSP;
                end else if (w_q.cnt == '0) begin
                    w_d.st       = WSM_IDLE;
                    commit_prog  = (w_q.kind == JOB_PROG);
                    commit_erase = (w_q.kind == JOB_ERASE);
                end else begin
                    w_d.cnt = w_q.cnt - 1'b1;
                end
            end
            WSM_SUSP: begin
                if (do_resume) w_d.st = WSM_BUSY;
            end
            default: w_d.st = WSM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q.st   <= WSM_IDLE;
            w_q.kind <= JOB_PROG;
            w_q.cnt  <= '0;
            w_q.addr <= '0;
            w_q.data <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign st       = w_q.st;
    assign kind     = w_q.kind;
    assign tgt_addr = w_q.addr;
    assign tgt_data = w_q.data;

endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int BLK_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_en,
    input  logic          erase_en,
    input  logic [AW-1:0] job_addr,
    input  logic [DW-1:0] job_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int WORDS = 1 << AW;
    localparam int BN_W  = AW - BLK_W;

    logic [DW-1:0] words [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam logic [BN_W-1:0] W_BLK  = BN_W'(w >> BLK_W);
        localparam logic [AW-1:0]   W_ADDR = AW'(w);
        logic          hit_prog, hit_erase;
        logic [DW-1:0] cell_d, cell_q;

        assign hit_prog  = prog_en  && (job_addr == W_ADDR);
        assign hit_erase = erase_en && (job_addr[AW-1:BLK_W] == W_BLK);

        always_comb begin
            cell_d = cell_q;
            if (hit_erase)     cell_d = '1;
            else if (hit_prog) cell_d = cell_q & job_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cell_q <= '1;
            else        cell_q <= cell_d;
        end

        assign words[w] = cell_q;
    end

    assign rd_data = words[rd_addr];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            DW        = 16,
    parameter int            BLK_W     = 4,
    parameter int            BOOT_BLK  = 0,
    parameter int            PROG_CYC  = 6,
    parameter int            ERASE_CYC = 20,
    parameter logic [DW-1:0] MFR_CODE  = 16'h00B0,
    parameter logic [DW-1:0] DEV_CODE  = 16'h00EC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    input  logic          prot_hv,
    output logic          ready
);

    localparam int BN_W = AW - BLK_W;

    logic          wr_stb;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    rd_mode_e      rd_mode;
    pend_e         pend;
    logic          err_erase, err_prog, err_prot;
    logic          go_prog, go_erase, do_susp, do_resume;
    wsm_st_e       wsm_st;
    job_e          wsm_kind;
    logic          commit_prog, commit_erase;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_data;
    logic [DW-1:0] arr_data;
    logic [7:0]    status;

    flash_bus_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    flash_cmd_decode #(.BN_W(BN_W), .BOOT_BLK(BOOT_BLK)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cmd(wr_data[7:0]),
        .wr_blk(wr_addr[AW-1:BLK_W]), .prot_hv(prot_hv), .wsm_st(wsm_st),
        .rd_mode(rd_mode), .pend(pend), .err_erase(err_erase), .err_prog(err_prog),
        .err_prot(err_prot), .go_prog(go_prog), .go_erase(go_erase),
        .do_susp(do_susp), .do_resume(do_resume)
    );

    flash_wsm #(.AW(AW), .DW(DW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_wsm (
        .clk(clk), .rst_n(rst_n), .go_prog(go_prog), .go_erase(go_erase),
        .do_susp(do_susp), .do_resume(do_resume), .job_addr(wr_addr), .job_data(wr_data),
        .st(wsm_st), .kind(wsm_kind), .commit_prog(commit_prog), .commit_erase(commit_erase),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data)
    );

    flash_array #(.AW(AW), .DW(DW), .BLK_W(BLK_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .prog_en(commit_prog), .erase_en(commit_erase),
        .job_addr(tgt_addr), .job_data(tgt_data), .rd_addr(addr), .rd_data(arr_data)
    );

    always_comb begin
        ready  = (wsm_st != WSM_BUSY);
        status = {ready,
                  (wsm_st == WSM_SUSP) && (wsm_kind == JOB_ERASE),
                  err_erase, err_prog, err_prot,
                  (wsm_st == WSM_SUSP) && (wsm_kind == JOB_PROG),
                  2'b00};
        dq_out = '0;
        if (!ce_n && !oe_n) begin
            case (rd_mode)
                RD_ARRAY:  dq_out = arr_data;
                RD_IDENT:  dq_out = addr[0] ? DEV_CODE : MFR_CODE;
                RD_STATUS: dq_out = {{(DW-8){1'b0}}, status};
                default:   dq_out = '0;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
    import flash_cmd_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int BLK_W    = 4,
    parameter int BOOT_BLK = 0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic [DW-1:0] dq_out,
    input logic          ready,
    input logic          prot_hv,
    input logic          wr_stb,
    input logic [AW-1:0] wr_addr,
    input logic [7:0]    cmd,
    input pend_e         pend,
    input rd_mode_e      rd_mode,
    input logic          go_prog,
    input logic          go_erase,
    input logic          do_susp
);

    localparam int BN_W = AW - BLK_W;
    localparam logic [BN_W-1:0] BOOT_IDX = BN_W'(BOOT_BLK);

    // R2
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (dq_out == '0));

    // R4
    status_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && rd_mode == RD_STATUS) |-> (dq_out[DW-1:8] == '0 && dq_out[1:0] == 2'b00));

    // R6
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_prog || go_erase) |=> !ready);

    // R9
    boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((go_prog || go_erase) && wr_addr[AW-1:BLK_W] == BOOT_IDX) |-> prot_hv);

    // R11
    suspend_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_susp |=> ready);

    // R12
    reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && pend == PEND_NONE && !op_known(cmd)) |=> ($stable(rd_mode) && pend == PEND_NONE));

endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.AW(AW), .DW(DW), .BLK_W(BLK_W), .BOOT_BLK(BOOT_BLK)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .dq_out(dq_out), .ready(ready),
    .prot_hv(prot_hv), .wr_stb(wr_stb), .wr_addr(wr_addr), .cmd(wr_data[7:0]), .pend(pend),
    .rd_mode(rd_mode), .go_prog(go_prog), .go_erase(go_erase), .do_susp(do_susp)
);

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;

    localparam int PROG_CYC  = 6;
    localparam int ERASE_CYC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        prot_hv = 1'b0;
    logic        ready;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    flash_cmd_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .prot_hv(prot_hv), .ready(ready)
    );

    // behavioural reference model
    logic [15:0] m_mem [256];
    bit          m_act;
    logic [7:0]  m_a;
    logic [15:0] m_d;
    int          m_mode;   // 0 array 1 ident 2 status
    int          m_pend;   // 0 none 1 erase 2 program
    bit          m_ee, m_pe, m_ve;
    int          m_st;     // 0 idle 1 busy 2 suspended
    int          m_kind;   // 0 program 1 erase
    int          m_cnt;
    logic [7:0]  m_ta;
    logic [15:0] m_td;

    function automatic logic [7:0] m_status();
        return {m_st != 1, m_st == 2 && m_kind == 1, m_ee, m_pe, m_ve, m_st == 2 && m_kind == 0, 2'b00};
    endfunction

    function automatic logic [15:0] m_read();
        if (ce_n || oe_n) return 16'h0000;
        if (m_mode == 0) return m_mem[addr];
        if (m_mode == 1) return addr[0] ? 16'h00EC : 16'h00B0;
        return {8'h00, m_status()};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
            m_act = 0; m_a = '0; m_d = '0; m_mode = 0; m_pend = 0;
            m_ee = 0; m_pe = 0; m_ve = 0; m_st = 0; m_kind = 0; m_cnt = 0; m_ta = '0; m_td = '0;
        end else begin
            bit act_now, stb, gp, ge, su, re, lock;
            act_now = !ce_n && !we_n;
            stb = m_act && !act_now;
            gp = 0; ge = 0; su = 0; re = 0;
            lock = (m_a[7:4] == 4'd0) && !prot_hv;
            if (stb) begin
                if (m_pend == 2) begin
                    m_pend = 0; m_mode = 2;
                    if (lock) begin m_ee = 1; m_pe = 1; m_ve = 1; end else gp = 1;
                end else if (m_pend == 1) begin
                    m_pend = 0; m_mode = 2;
                    if (m_d[7:0] != 8'hD0) begin m_ee = 1; m_pe = 1; end
                    else if (lock) begin m_ee = 1; m_pe = 1; m_ve = 1; end
                    else ge = 1;
                end else begin
                    case (m_d[7:0])
                        8'hFF: m_mode = 0;
                        8'h90: m_mode = 1;
                        8'h70: m_mode = 2;
                        8'h50: begin m_ee = 0; m_pe = 0; m_ve = 0; end
                        8'h20: if (m_st == 0) begin m_pend = 1; m_mode = 2; end
                        8'h40, 8'h10: if (m_st == 0) begin m_pend = 2; m_mode = 2; end
                        8'hB0: begin m_mode = 2; su = (m_st == 1); end
                        8'hD0: begin m_mode = 2; re = (m_st == 2); end
                        default: ;
                    endcase
                end
            end
            case (m_st)
                0: if (gp) begin m_st = 1; m_kind = 0; m_cnt = PROG_CYC - 1; m_ta = m_a; m_td = m_d; end
                   else if (ge) begin m_st = 1; m_kind = 1; m_cnt = ERASE_CYC - 1; m_ta = m_a; end
                1: if (su) m_st = 2;
                   else if (m_cnt == 0) begin
                       m_st = 0;
                       if (m_kind == 0) m_mem[m_ta] = m_mem[m_ta] & m_td;
                       else for (int i = 0; i < 16; i++) m_mem[{m_ta[7:4], 4'(i)}] = 16'hFFFF;
                   end else m_cnt--;
                default: if (re) m_st = 1;
            endcase
            m_act = act_now;
            if (act_now) begin m_a = addr; m_d = dq_in; end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            logic [15:0] exp_dq;
            exp_dq = m_read();
            checks++;
            if (dq_out !== exp_dq || ready !== (m_st != 1)) begin
                fails++;
                $display("FAIL %s: model compare dq_out=%h ready=%b expected dq_out=%h ready=%b",
                         cur_req, dq_out, ready, exp_dq, m_st != 1);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        ce_n = 0; we_n = 0; oe_n = 1; addr = a; dq_in = d;
        @(negedge clk);
        we_n = 1; ce_n = 1; dq_in = 16'h0000;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] v);
        @(negedge clk);
        ce_n = 0; oe_n = 0; addr = a;
        #3 v = dq_out;
        @(negedge clk);
        ce_n = 1; oe_n = 1;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (ready) break;
        end
    endtask

    logic [15:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        cur_req = "R1";
        bus_read(8'h05, v); chk("R1 array word after reset", v, 16'hFFFF);
        chk("R1 ready after reset", {15'd0, ready}, 16'h0001);
        bus_write(8'h00, 16'h0070);
        bus_read(8'h33, v); chk("R1 R4 status after reset", v, 16'h0080);

        // R2: quiet bus when output disabled
        cur_req = "R2";
        @(negedge clk); ce_n = 0; oe_n = 1; addr = 8'h05; #3 chk("R2 oe_n high", dq_out, 16'h0000);
        @(negedge clk); ce_n = 1;

        // R6: program with both setup codes
        cur_req = "R6";
        bus_write(8'h25, 16'h0040);
        bus_write(8'h25, 16'h1234);
        chk("R6 busy after launch", {15'd0, ready}, 16'h0000);
        wait_ready();
        bus_write(8'h00, 16'h00FF);
        bus_read(8'h25, v); chk("R6 programmed word", v, 16'h1234);
        bus_write(8'h25, 16'h0010);
        bus_write(8'h25, 16'hFF0F);
        wait_ready();
        bus_read(8'h99, v); chk("R6 status mode after program", v, 16'h0080);
        bus_write(8'h00, 16'h00FF);
        bus_read(8'h25, v); chk("R6 AND-only program", v, 16'h1204);

        // R3: identifier codes
        cur_req = "R3";
        bus_write(8'h10, 16'h0090);
        bus_read(8'h00, v); chk("R3 even address", v, 16'h00B0);
        bus_read(8'h01, v); chk("R3 odd address", v, 16'h00EC);

        // R7: block erase
        cur_req = "R7";
        bus_write(8'h00, 16'h00FF);
        bus_write(8'h3F, 16'h0040); bus_write(8'h3F, 16'h0000); wait_ready();
        bus_write(8'h00, 16'h0020);
        bus_write(8'h21, 16'h00D0);
        wait_ready();
        bus_write(8'h00, 16'h00FF);
        bus_read(8'h25, v); chk("R7 erased word in block", v, 16'hFFFF);
        bus_read(8'h3F, v); chk("R7 neighbour block untouched", v, 16'h0000);

        // R8 / R10: bad confirm and clear
        cur_req = "R8";
        bus_write(8'h00, 16'h0020);
        bus_write(8'h3F, 16'h0033);
        bus_read(8'h00, v); chk("R8 bad confirm status", v, 16'h00B0);
        bus_write(8'h00, 16'h00FF);
        bus_read(8'h3F, v); chk("R8 no erase", v, 16'h0000);
        cur_req = "R10";
        bus_write(8'h00, 16'h0050);
        bus_write(8'h00, 16'h0070);
        bus_read(8'h00, v); chk("R10 cleared", v, 16'h0080);

        // R9: boot block protection
        cur_req = "R9";
        prot_hv = 0;
        bus_write(8'h03, 16'h0040); bus_write(8'h03, 16'h00FF);
        bus_read(8'h00, v); chk("R9 locked program status", v, 16'h00B8);
        bus_write(8'h00, 16'h0050);
        bus_write(8'h00, 16'h0020); bus_write(8'h07, 16'h00D0);
        bus_read(8'h00, v); chk("R9 locked erase status", v, 16'h00B8);
        bus_write(8'h00, 16'h0050);
        bus_write(8'h00, 16'h00FF);
        bus_read(8'h03, v); chk("R9 boot word unchanged", v, 16'hFFFF);
        prot_hv = 1;
        bus_write(8'h03, 16'h0040); bus_write(8'h03, 16'h00FF); wait_ready();
        bus_write(8'h00, 16'h00FF);
        bus_read(8'h03, v); chk("R9 boot program with hv", v, 16'h00FF);
        prot_hv = 0;

        // R11: program suspend / resume
        cur_req = "R11";
        bus_write(8'h40, 16'h0040);
        bus_write(8'h40, 16'h0000);
        bus_write(8'h00, 16'h00B0);
        bus_read(8'h00, v); chk("R11 program suspended status", v, 16'h0084);
        bus_write(8'h00, 16'h00FF);
        bus_read(8'h40, v); chk("R11 array old during suspend", v, 16'hFFFF);
        bus_write(8'h00, 16'h00D0);
        wait_ready();
        bus_write(8'h00, 16'h00FF);
        bus_read(8'h40, v); chk("R11 program completes after resume", v, 16'h0000);
        bus_write(8'h00, 16'h0020);
        bus_write(8'h41, 16'h00D0);
        bus_write(8'h00, 16'h00B0);
        bus_read(8'h00, v); chk("R11 erase suspended status", v, 16'h00C0);
        bus_write(8'h00, 16'h00FF);
        bus_read(8'h40, v); chk("R11 erase not applied yet", v, 16'h0000);
        bus_write(8'h00, 16'h00D0);
        wait_ready();
        bus_write(8'h00, 16'h00FF);
        bus_read(8'h40, v); chk("R11 erase completes after resume", v, 16'hFFFF);

        // R12: reserved code and setup while busy
        cur_req = "R12";
        bus_write(8'h00, 16'h00A5);
        bus_read(8'h40, v); chk("R12 reserved keeps array mode", v, 16'hFFFF);
        bus_write(8'h50, 16'h0040);
        bus_write(8'h50, 16'h00AA);
        bus_write(8'h00, 16'h0020);
        wait_ready();
        bus_write(8'h00, 16'h0033);
        bus_read(8'h00, v); chk("R12 setup ignored while busy", v, 16'h0080);
        bus_write(8'h00, 16'h00FF);
        bus_read(8'h50, v); chk("R12 program result", v, 16'h00AA);

        // R5: strobe order for capture
        cur_req = "R5";
        @(negedge clk); ce_n = 0; we_n = 0; addr = 8'h61; dq_in = 16'h0090;
        @(negedge clk); we_n = 1; dq_in = 16'h00FF; addr = 8'h60;
        @(negedge clk); ce_n = 1;
        @(negedge clk);
        bus_read(8'h01, v); chk("R5 write-enable rises first", v, 16'h00EC);
        bus_write(8'h62, 16'h0040);
        @(negedge clk); ce_n = 0; we_n = 0; addr = 8'h62; dq_in = 16'h0F0F;
        @(negedge clk); ce_n = 1; addr = 8'h63; dq_in = 16'h0000;
        @(negedge clk); we_n = 1;
        wait_ready();
        bus_write(8'h00, 16'h00FF);
        bus_read(8'h62, v); chk("R5 chip-enable rises first", v, 16'h0F0F);
        bus_read(8'h63, v); chk("R5 later address not used", v, 16'hFFFF);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule